// File: doc/BRIEF.md
# Serial Port Interrupt Flag Controller

This block keeps the status flags and interrupt request lines of a simple serial port. The datapath around it (shift registers, baud timing, line protocol) is outside the block and shows up only as single-cycle event strobes. There is one strobe for each of five conditions: transmit buffer emptied, receive buffer filled, framing error, parity error and overrun. Each strobe sets a sticky flag in a status register. A control register holds two enables that gate the flags onto three registered interrupt lines: transmit, receive and receive-error.

Software reaches both registers through a small synchronous register bus with read and write strobes and a one-bit address. A flag cannot be cleared by a single write. The CPU must first read the flag while it is 1, which arms that flag. A later write with a 0 in that bit position then clears it. Writing 1 never sets a flag, and a hardware event in the same cycle as a clear keeps the flag set. The single receive enable gates both the data-full interrupt and the error interrupt.

Top module: `serial_irq_flags`

## Requirements
- R1: Address 0 selects the control register. Bit 7 is the transmit interrupt enable and bit 6 is the receive interrupt enable. Both reset to 0 and can be read and written at any time. Bits 5..0 read as 0.
- R2: Address 1 selects the status register. Bit 0 is transmit-empty, bit 1 is receive-full, bit 2 is framing error, bit 3 is parity error and bit 4 is overrun. Bits 7..5 read as 0 and the value after reset is 0x01. Read data appears on bus_rdata the cycle after the read strobe and holds until the next read.
- R3: A one-cycle event strobe sets its flag, and the new value is visible from the next clock edge.
- R4: tx_irq is registered. It equals (transmit-empty AND transmit enable) one cycle after those values.
- R5: rx_irq equals (receive-full AND receive enable), and err_irq equals (any of the three error flags AND receive enable), each registered one cycle late. While the receive enable is 0, both stay low.
- R6: A status read that returns 1 in a bit arms that flag. A later status write with 0 in that bit clears the flag and the arm. A write of 0 to an unarmed flag leaves it at 1.
- R7: Writing 1 to any status bit has no effect on the flags.
- R8: If an event strobe and an armed clear meet in the same cycle, the flag stays 1 and the arm is used up, so a fresh read of 1 is needed before the next clear.
- R9: Clearing an enable bit withdraws the matching interrupt one cycle after the write takes effect, while the flag stays set.
- R10: Reset sets transmit-empty, clears every other flag, clears all arms and drives all interrupts low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 selects control, 1 selects status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ev_tx_empty | input | 1 | Transmit data moved into the shift stage |
| ev_rx_full | input | 1 | Received data moved into the receive data register |
| ev_frame_err | input | 1 | Framing error detected |
| ev_parity_err | input | 1 | Parity error detected |
| ev_overrun | input | 1 | Overrun detected |
| tx_irq | output | 1 | Transmit-data-empty interrupt |
| rx_irq | output | 1 | Receive-data-full interrupt |
| err_irq | output | 1 | Receive-error interrupt |

## Verification
The hidden state is the arm bit of each flag. A wrong arm bit is not visible when it goes wrong. It shows only at the next status write with a 0 in that bit: a flag then clears without a prior read, or fails to clear after one. The next status read shows the result, and an interrupt line shows it one cycle after that. A wrong flag or enable shows on its interrupt line exactly one clock after the fault, so the bench checks the lines both in the cycle just after a change and in the cycle after that.

// File: rtl/sif_pkg.sv
package sif_pkg;
  localparam int NUM_FLAGS = 5;

  localparam int FLG_TXE = 0;
  localparam int FLG_RXF = 1;
  localparam int FLG_FER = 2;
  localparam int FLG_PER = 3;
  localparam int FLG_ORE = 4;

  localparam logic [NUM_FLAGS-1:0] FLAGS_RESET = 5'b00001;

  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_STAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/sif_flag_cell.sv
module sif_flag_cell #(
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic hw_set_i,
  input  logic rd_stb_i,
  input  logic wr_stb_i,
  input  logic wr_bit_i,
  output logic flag_o
);
  logic flag_q;
  logic armed_q;
  logic clr_req;

  assign clr_req = wr_stb_i && !wr_bit_i && armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= RESET_VAL;
      armed_q <= 1'b0;
    end else begin
      if (hw_set_i)     flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;

      if (clr_req)                  armed_q <= 1'b0;
      else if (rd_stb_i && flag_q)  armed_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  // R3
  set_takes_chk: assert property (@(posedge clk) disable iff (rst)
    hw_set_i |=> flag_q);

  // R7
  rise_only_by_event_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(hw_set_i));

  // R6
  fall_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(armed_q && wr_stb_i && !wr_bit_i));
endmodule

// File: rtl/sif_ctrl_reg.sv
module sif_ctrl_reg #(
  parameter int DATA_W  = 8,
  parameter int TIE_POS = 7,
  parameter int RIE_POS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              tie_o,
  output logic              rie_o,
  output logic [DATA_W-1:0] view_o
);
  logic tie_q, rie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tie_q <= 1'b0;
      rie_q <= 1'b0;
    end else if (wr_i) begin
      tie_q <= wdata_i[TIE_POS];
      rie_q <= wdata_i[RIE_POS];
    end
  end

  always_comb begin
    view_o          = '0;
    view_o[TIE_POS] = tie_q;
    view_o[RIE_POS] = rie_q;
  end

  assign tie_o = tie_q;
  assign rie_o = rie_q;

  // R1
  enables_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable({tie_q, rie_q}) |-> $past(wr_i));
endmodule

// File: rtl/sif_irq_gen.sv
module sif_irq_gen (
  input  logic       clk,
  input  logic       rst,
  input  logic       txe_i,
  input  logic       rxf_i,
  input  logic [2:0] errs_i,
  input  logic       tie_i,
  input  logic       rie_i,
  output logic       tx_irq_o,
  output logic       rx_irq_o,
  output logic       err_irq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_irq_o  <= 1'b0;
      rx_irq_o  <= 1'b0;
      err_irq_o <= 1'b0;
    end else begin
      tx_irq_o  <= txe_i && tie_i;
      rx_irq_o  <= rxf_i && rie_i;
      err_irq_o <= (|errs_i) && rie_i;
    end
  end

  // R4
  tx_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    tx_irq_o |-> $past(txe_i && tie_i));

  // R5
  rie_gates_both_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rie_i) |-> (!rx_irq_o && !err_irq_o));

  // R5
  err_needs_error_chk: assert property (@(posedge clk) disable iff (rst)
    err_irq_o |-> $past(|errs_i));

  // R9
  enable_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tie_i) |=> !tx_irq_o);
endmodule

// File: rtl/serial_irq_flags.sv
module serial_irq_flags #(
  parameter int DATA_W  = 8,
  parameter int TIE_POS = 7,
  parameter int RIE_POS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ev_tx_empty,
  input  logic              ev_rx_full,
  input  logic              ev_frame_err,
  input  logic              ev_parity_err,
  input  logic              ev_overrun,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic              err_irq
);
  import sif_pkg::*;

  localparam int NF = NUM_FLAGS;

  logic              stat_rd, stat_wr, ctrl_wr;
  logic [NF-1:0]     hw_set;
  logic [NF-1:0]     flags;
  logic [DATA_W-1:0] stat_view, ctrl_view;
  logic              tie, rie;

  assign stat_rd = bus_rd && (bus_addr == REG_STAT);
  assign stat_wr = bus_wr && (bus_addr == REG_STAT);
  assign ctrl_wr = bus_wr && (bus_addr == REG_CTRL);

  always_comb begin
    hw_set          = '0;
    hw_set[FLG_TXE] = ev_tx_empty;
    hw_set[FLG_RXF] = ev_rx_full;
    hw_set[FLG_FER] = ev_frame_err;
    hw_set[FLG_PER] = ev_parity_err;
    hw_set[FLG_ORE] = ev_overrun;
  end

  for (genvar i = 0; i < NF; i++) begin : g_flag
    sif_flag_cell #(.RESET_VAL(FLAGS_RESET[i])) u_cell (
      .clk      (clk),
      .rst      (rst),
      .hw_set_i (hw_set[i]),
      .rd_stb_i (stat_rd),
      .wr_stb_i (stat_wr),
      .wr_bit_i (bus_wdata[i]),
      .flag_o   (flags[i])
    );
  end

  sif_ctrl_reg #(.DATA_W(DATA_W), .TIE_POS(TIE_POS), .RIE_POS(RIE_POS)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (ctrl_wr),
    .wdata_i (bus_wdata),
    .tie_o   (tie),
    .rie_o   (rie),
    .view_o  (ctrl_view)
  );

  sif_irq_gen u_irq (
    .clk       (clk),
    .rst       (rst),
    .txe_i     (flags[FLG_TXE]),
    .rxf_i     (flags[FLG_RXF]),
    .errs_i    ({flags[FLG_ORE], flags[FLG_PER], flags[FLG_FER]}),
    .tie_i     (tie),
    .rie_i     (rie),
    .tx_irq_o  (tx_irq),
    .rx_irq_o  (rx_irq),
    .err_irq_o (err_irq)
  );

  always_comb begin
    stat_view       = '0;
    stat_view[NF-1:0] = flags;
  end

  always_ff @(posedge clk) begin
    if (rst)          bus_rdata <= '0;
    else if (bus_rd)  bus_rdata <= (bus_addr == REG_STAT) ? stat_view : ctrl_view;
  end

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> $stable(bus_rdata));

  // R2
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(stat_rd) |-> (bus_rdata[DATA_W-1:NF] == '0));
endmodule

// File: tb/serial_irq_flags_test.sv
module serial_irq_flags_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       bus_rd, bus_wr, bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [4:0] ev;
  logic       tx_irq, rx_irq, err_irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  serial_irq_flags uut (
    .clk(clk), .rst(rst),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_tx_empty(ev[0]), .ev_rx_full(ev[1]), .ev_frame_err(ev[2]),
    .ev_parity_err(ev[3]), .ev_overrun(ev[4]),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .err_irq(err_irq)
  );

  // vector: [9] tx enable, [8] rx enable, [7:3] events, [2:0] expected {err,rx,tx}
  localparam logic [9:0] VEC [10] = '{
    {2'b10, 5'b00001, 3'b001},
    {2'b00, 5'b00001, 3'b000},
    {2'b01, 5'b00010, 3'b010},
    {2'b10, 5'b00010, 3'b000},
    {2'b01, 5'b00100, 3'b100},
    {2'b01, 5'b01000, 3'b100},
    {2'b01, 5'b10000, 3'b100},
    {2'b11, 5'b11111, 3'b111},
    {2'b10, 5'b11110, 3'b000},
    {2'b01, 5'b00011, 3'b010}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    cyc();
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic pulse(input logic [4:0] m);
    ev = m;
    cyc();
    ev = 5'b0;
  endtask

  task automatic clear_all();
    logic [7:0] d;
    bus_read(1'b1, d);
    bus_write(1'b1, 8'h00);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) cyc();
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; ev = 0;
    cyc();
    do_reset();

    // R10 / R2 reset values
    check("R10 irqs after reset", {5'b0, err_irq, rx_irq, tx_irq}, 8'h00);
    bus_read(1'b1, d);
    check("R2 status reset value", d, 8'h01);
    bus_read(1'b0, d);
    check("R1 control reset value", d, 8'h00);
    check("R2 rdata holds", bus_rdata, 8'h00);

    // R1 control readback
    bus_write(1'b0, 8'hFF);
    bus_read(1'b0, d);
    check("R1 only enable bits stored", d, 8'hC0);
    bus_write(1'b0, 8'h40);
    bus_read(1'b0, d);
    check("R1 rx enable alone", d, 8'h40);

    // vector loop: R3 R4 R5
    for (int i = 0; i < 10; i++) begin
      bus_write(1'b0, 8'h00);
      clear_all();
      bus_write(1'b0, {VEC[i][9:8], 6'b0});
      pulse(VEC[i][7:3]);
      cyc();
      check($sformatf("R4 R5 vector %0d irqs", i),
            {5'b0, err_irq, rx_irq, tx_irq}, {5'b0, VEC[i][2:0]});
      bus_read(1'b1, d);
      check($sformatf("R3 vector %0d status", i), d, {3'b0, VEC[i][7:3]});
    end

    // R4 latency: one cycle after flag
    bus_write(1'b0, 8'h00);
    clear_all();
    bus_write(1'b0, 8'h80);
    pulse(5'b00001);
    check("R4 irq not yet at flag cycle", {7'b0, tx_irq}, 8'h00);
    cyc();
    check("R4 irq one cycle later", {7'b0, tx_irq}, 8'h01);

    // R9 withdraw by disabling
    bus_write(1'b0, 8'h00);
    cyc();
    check("R9 tx irq withdrawn", {7'b0, tx_irq}, 8'h00);
    bus_read(1'b1, d);
    check("R9 flag still set", d, 8'h01);
    bus_write(1'b0, 8'h80);
    cyc();
    check("R9 irq returns on re-enable", {7'b0, tx_irq}, 8'h01);

    // R6 two-step clear withdraws irq (flag armed by read above)
    bus_write(1'b1, 8'h00);
    cyc();
    check("R6 armed clear drops irq", {7'b0, tx_irq}, 8'h00);
    bus_read(1'b1, d);
    check("R6 armed clear", d, 8'h00);

    // R6 write 0 without arm
    pulse(5'b00010);
    bus_write(1'b1, 8'h00);
    bus_read(1'b1, d);
    check("R6 unarmed write keeps flag", d, 8'h02);
    bus_write(1'b1, 8'h00);
    bus_read(1'b1, d);
    check("R6 clear after read", d, 8'h00);

    // R7 write 1 does not set
    bus_write(1'b1, 8'hFF);
    bus_read(1'b1, d);
    check("R7 write ones no effect", d, 8'h00);
    bus_write(1'b0, 8'hC0);
    cyc();
    check("R7 no irq from write ones", {5'b0, err_irq, rx_irq, tx_irq}, 8'h00);

    // R8 set beats clear, arm consumed
    pulse(5'b00010);
    bus_read(1'b1, d);
    ev = 5'b00010;
    bus_write(1'b1, 8'h00);
    ev = 5'b0;
    bus_read(1'b1, d);
    check("R8 set wins", d, 8'h02);
    clear_all();
    bus_write(1'b1, 8'h00);
    pulse(5'b00010);
    bus_write(1'b1, 8'h00);
    bus_read(1'b1, d);
    check("R8 arm used up", d, 8'h02);

    // R8 arm consumed by losing clear, so next write needs fresh read
    ev = 5'b00010;
    bus_write(1'b1, 8'h00);
    ev = 5'b0;
    bus_write(1'b1, 8'h00);
    bus_read(1'b1, d);
    check("R8 no clear without new read", d, 8'h02);

    // R10 reset clears arms
    bus_read(1'b1, d);
    do_reset();
    bus_write(1'b1, 8'h00);
    bus_read(1'b1, d);
    check("R10 arm cleared by reset", d, 8'h01);
    bus_read(1'b0, d);
    check("R10 control cleared", d, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule